// File: doc/BRIEF.md
# Link Settle Window Monitor

This block watches the link-status word of a downstream serial-link port for a bounded observation window and decides whether the link has settled. Software or a sequencer elsewhere reads the status word and presents it here with a valid strobe. A separate free-running tick strobe measures time. The block itself only classifies what it observes. It never fetches the status word and never changes any link setting.

A start pulse opens a window. The first valid status word after the start is used only to seed the previous value of the training flag. Every later valid word is a counted sample. The window closes early when a sample shows the link-active flag. Otherwise it closes after a parameterised number of ticks, which is normally set so that the window spans 200 ms at the chosen tick rate.

When the window closes, the block gives a one-cycle done pulse and a stable/unstable verdict. It also gives four diagnostic counters: total samples, samples taken while training, the final run of non-training samples, and training-flag transitions. All of these hold their values until the next start.

Top module: `link_settle_mon`

## Requirements
- R1: After reset, donePulse is low and all four counters read zero.
- R2: A start pulse while idle clears all counters and opens a window. The first valid word after that start only loads the previous-training flag. It is not counted, and its link-active bit (bit 13) is not acted on.
- R3: For each counted sample, sampleCount increments. If the training bit (bit 11) is set, trainCount increments and quietRun clears. Otherwise quietRun increments.
- R4: flipCount increments on each counted sample whose training bit differs from the training bit of the previous word, including the seeding word.
- R5: A counted sample with bit 13 set is counted normally and ends the window. donePulse is high in the next cycle.
- R6: Without an early end, donePulse is high in the second cycle after the cycle that carries the WINDOW_TICKS-th tick since the start. Ticks are counted only while the window is open.
- R7: linkStable is 1 when link-active was seen, or when quietRun >= sampleCount/2 (integer division). Otherwise it is 0.
- R8: donePulse lasts exactly one cycle. Valid words arriving after the window closes change no output until the next start.
- R9: A start pulse while a window is open is ignored. The counters are not cleared and the window timing is not restarted.
- R10: Each counter saturates at its all-ones value instead of wrapping.
- R11: Status bits other than 11 and 13 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Opens an observation window when the block is idle |
| statusWord | input | 16 | Sampled link-status word (bit 11 training, bit 13 link active) |
| statusValid | input | 1 | statusWord carries a fresh sample this cycle |
| tick | input | 1 | One-cycle time-base strobe |
| donePulse | output | 1 | One-cycle pulse when the window closes |
| linkStable | output | 1 | Verdict, meaningful from donePulse until next start |
| sampleCount | output | CNT_W | Counted samples |
| trainCount | output | CNT_W | Counted samples with training set |
| quietRun | output | CNT_W | Trailing run of non-training samples |
| flipCount | output | CNT_W | Training-flag transitions |

## Verification
The bench builds the block with WINDOW_TICKS = 8 and CNT_W = 4. The short window makes the exact expiry cycle cheap to pin down, and the 4-bit counters saturate at 15 within about twenty samples. With that configuration the bench sweeps every five-sample training pattern under both seed values and compares the results with counts computed arithmetically. Directed runs then cover an early exit at several positions, an empty window, a stray start, a seeding word with link-active set, and saturation of every counter.

// File: rtl/link_settle_pkg.sv
package link_settle_pkg;

  // Bit positions decoded from the link-status word
  localparam int TRAIN_POS  = 11;
  localparam int ACTIVE_POS = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEED  = 2'd1,
    ST_WATCH = 2'd2,
    ST_DONE  = 2'd3
  } monState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic seedEn;
    logic sampleEn;
  } dpCtl_t;

endpackage

// File: rtl/link_settle_ctrl.sv
module link_settle_ctrl
  import link_settle_pkg::*;
#(
  parameter int WINDOW_TICKS = 200
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   tick,
  input  logic   statusValid,
  input  logic   activeBit,
  output dpCtl_t dpCtl,
  output logic   donePulse
);

  localparam int TW = $clog2(WINDOW_TICKS + 1);
  localparam logic [TW-1:0] TICK_LIMIT = TW'(WINDOW_TICKS);

  monState_t state, nextState;
  logic [TW-1:0] tickCnt;
  logic expired;
  logic windowOpen;

  assign windowOpen = (state == ST_SEED) || (state == ST_WATCH);
  assign expired    = (tickCnt == TICK_LIMIT);
  assign donePulse  = (state == ST_DONE);

  always_comb begin
    nextState = state;
    dpCtl     = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          nextState      = ST_SEED;
          dpCtl.clearAll = 1'b1;
        end
      end
      ST_SEED: begin
        if (expired) begin
          nextState = ST_DONE;
        end else if (statusValid) begin
          dpCtl.seedEn = 1'b1;
          nextState    = ST_WATCH;
        end
      end
      ST_WATCH: begin
        if (expired) begin
          nextState = ST_DONE;
        end else if (statusValid) begin
          dpCtl.sampleEn = 1'b1;
          if (activeBit) nextState = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      state <= nextState;
      if (dpCtl.clearAll) begin
        tickCnt <= '0;
      end else if (windowOpen && tick && !expired) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // R8: the done strobe never spans two cycles
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9: a start seen mid-window does not reopen the seeding phase
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WATCH && startPulse) |=> (state != ST_SEED));

  // R5: a link-active sample inside the window ends it on the next cycle
  assert_early_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WATCH && !expired && statusValid && activeBit) |=> donePulse);

  // R6: an expired window closes on the next cycle
  assert_expiry_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (windowOpen && expired) |=> donePulse);

endmodule

// File: rtl/link_settle_dp.sv
module link_settle_dp
  import link_settle_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [15:0]      statusWord,
  output logic             activeBit,
  output logic             linkStable,
  output logic [CNT_W-1:0] sampleCnt,
  output logic [CNT_W-1:0] trainCnt,
  output logic [CNT_W-1:0] quietCnt,
  output logic [CNT_W-1:0] flipCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic trainBit;
  logic prevTrain;
  logic activeSeen;

  assign trainBit  = statusWord[TRAIN_POS];
  assign activeBit = statusWord[ACTIVE_POS];

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt  <= '0;
      trainCnt   <= '0;
      quietCnt   <= '0;
      flipCnt    <= '0;
      prevTrain  <= 1'b0;
      activeSeen <= 1'b0;
    end else if (dpCtl.clearAll) begin
      sampleCnt  <= '0;
      trainCnt   <= '0;
      quietCnt   <= '0;
      flipCnt    <= '0;
      prevTrain  <= 1'b0;
      activeSeen <= 1'b0;
    end else if (dpCtl.seedEn) begin
      prevTrain <= trainBit;
    end else if (dpCtl.sampleEn) begin
      sampleCnt <= satInc(sampleCnt);
      if (trainBit) begin
        trainCnt <= satInc(trainCnt);
        quietCnt <= '0;
      end else begin
        quietCnt <= satInc(quietCnt);
      end
      if (trainBit != prevTrain) flipCnt <= satInc(flipCnt);
      prevTrain <= trainBit;
      if (activeBit) activeSeen <= 1'b1;
    end
  end

  assign linkStable = activeSeen || (quietCnt >= (sampleCnt >> 1));

  // R10: a saturated sample counter stays saturated until cleared
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleCnt == CNT_MAX && !dpCtl.clearAll) |=> (sampleCnt == CNT_MAX));

  // R3: the sub-counts never exceed the total number of samples
  assert_train_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trainCnt <= sampleCnt) && (quietCnt <= sampleCnt));

  // R4: transitions never outnumber samples
  assert_flips_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    flipCnt <= sampleCnt);

  // R8: without a control strobe the counters hold
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.clearAll && !dpCtl.sampleEn) |=> ($stable(sampleCnt) && $stable(flipCnt)));

endmodule

// File: rtl/link_settle_mon.sv
module link_settle_mon
  import link_settle_pkg::*;
#(
  parameter int WINDOW_TICKS = 200,
  parameter int CNT_W        = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [15:0]      statusWord,
  input  logic             statusValid,
  input  logic             tick,
  output logic             donePulse,
  output logic             linkStable,
  output logic [CNT_W-1:0] sampleCount,
  output logic [CNT_W-1:0] trainCount,
  output logic [CNT_W-1:0] quietRun,
  output logic [CNT_W-1:0] flipCount
);

  dpCtl_t dpCtl;
  logic   activeBit;

  link_settle_ctrl #(
    .WINDOW_TICKS(WINDOW_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .tick       (tick),
    .statusValid(statusValid),
    .activeBit  (activeBit),
    .dpCtl      (dpCtl),
    .donePulse  (donePulse)
  );

  link_settle_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .statusWord(statusWord),
    .activeBit (activeBit),
    .linkStable(linkStable),
    .sampleCnt (sampleCount),
    .trainCnt  (trainCount),
    .quietCnt  (quietRun),
    .flipCnt   (flipCount)
  );

endmodule

// File: tb/link_settle_mon_bench.sv
module link_settle_mon_bench;

  localparam int WT   = 8;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [15:0]   statusWord = '0;
  logic          statusValid = 1'b0;
  logic          tick = 1'b0;
  logic          donePulse;
  logic          linkStable;
  logic [CW-1:0] sampleCount, trainCount, quietRun, flipCount;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  link_settle_mon #(.WINDOW_TICKS(WT), .CNT_W(CW)) u_link_settle_mon (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .statusWord(statusWord),
    .statusValid(statusValid), .tick(tick), .donePulse(donePulse),
    .linkStable(linkStable), .sampleCount(sampleCount), .trainCount(trainCount),
    .quietRun(quietRun), .flipCount(flipCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic logic [15:0] mkWord(input bit tr, input bit act, input bit junk, input int salt);
    logic [15:0] other;
    other = junk ? (16'(salt * 16'h3A5B + 16'h1C7) & 16'hD7FF) : 16'h0;
    return other | (16'(tr) << 11) | (16'(act) << 13);
  endfunction

  // One full window; expected values follow the requirements arithmetically
  task automatic runCase(input bit seedTr, input bit seedAct, input int nSamp,
                         input logic [31:0] mask, input int actIdx,
                         input bit junk, input int strayAt);
    int s, t, q, f, stable;
    bit prev, act;
    prev = seedTr; s = 0; t = 0; q = 0; f = 0; act = 0;
    for (int i = 0; i < nSamp; i++) begin
      s = sat(s);
      if (mask[i]) begin t = sat(t); q = 0; end else q = sat(q);
      if (mask[i] != prev) f = sat(f);
      prev = mask[i];
      if (i == actIdx) begin act = 1; break; end
    end
    stable = (act || q >= s / 2) ? 1 : 0;

    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    statusWord = mkWord(seedTr, seedAct, junk, 99); statusValid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < nSamp; i++) begin
      if (i == strayAt) startPulse = 1'b1;
      statusWord = mkWord(mask[i], i == actIdx, junk, i);
      statusValid = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      if (i == actIdx) break;
    end
    statusValid = 1'b0;
    if (actIdx >= 0 && actIdx < nSamp) begin
      chk("R5 early done", int'(donePulse), 1);
    end else begin
      for (int k = 0; k < WT; k++) begin
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
      end
      chk("R6 not yet done", int'(donePulse), 0);
      @(negedge clk);
      chk("R6 done at expiry", int'(donePulse), 1);
    end
    chk("R3 sampleCount", int'(sampleCount), s);
    chk("R3 trainCount", int'(trainCount), t);
    chk("R3 quietRun", int'(quietRun), q);
    chk("R4 flipCount", int'(flipCount), f);
    chk("R7 verdict", int'(linkStable), stable);
    @(negedge clk);
    chk("R8 done one cycle", int'(donePulse), 0);
    for (int k = 0; k < 2; k++) begin
      statusWord = mkWord(k[0], 1'b0, 1'b0, k); statusValid = 1'b1; tick = 1'b1;
      @(negedge clk);
    end
    statusValid = 1'b0; tick = 1'b0;
    chk("R8 hold sampleCount", int'(sampleCount), s);
    chk("R8 hold flipCount", int'(flipCount), f);
    chk("R8 hold verdict", int'(linkStable), stable);
    chk("R8 no second done", int'(donePulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset done", int'(donePulse), 0);
    chk("R1 reset counts", int'(sampleCount | trainCount | quietRun | flipCount), 0);

    // R3 R4 R7 R11: every five-sample pattern under both seeds
    for (int sd = 0; sd < 2; sd++)
      for (int m = 0; m < 32; m++)
        runCase(sd[0], 1'b0, 5, 32'(m), -1, m[0] ^ sd[0], -1);

    // R5: early exit at several positions
    runCase(1'b0, 1'b0, 5, 32'b10110, 2, 1'b0, -1);
    runCase(1'b1, 1'b0, 5, 32'b11111, 0, 1'b1, -1);
    runCase(1'b0, 1'b0, 5, 32'b01111, 4, 1'b0, -1);
    // R6 R7: empty window
    runCase(1'b1, 1'b0, 0, 32'h0, -1, 1'b0, -1);
    // R2: link-active on the seeding word is not acted on
    runCase(1'b1, 1'b1, 3, 32'b111, -1, 1'b0, -1);
    // R9: stray start mid-window
    runCase(1'b0, 1'b0, 5, 32'b00101, -1, 1'b0, 2);
    // R10: saturation of every counter
    runCase(1'b0, 1'b0, 20, 32'hAAAAA, -1, 1'b0, -1);
    runCase(1'b0, 1'b0, 20, 32'hFFFFF, -1, 1'b1, -1);
    runCase(1'b1, 1'b0, 20, 32'h00000, -1, 1'b0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule